// File: doc/BRIEF.md
# Bit-Serial Variable-Precision Multiply-Accumulate

This block forms the sum of three signed products, one per lane, without any multiplier. Each lane holds a 16-bit signed activation and a 16-bit signed weight. The block first moves every negative weight's sign onto its activation, so that only the weight's magnitude is walked bit by bit. In each clock the current magnitude bits pick which activations are added. That sum is shifted by the bit's true position and added to a wide accumulator.

The caller picks a precision from 1 to 16 with every operation. Precision p keeps only the p most significant magnitude bits of each weight and drops the rest. After masking, the block finds the lowest and the highest bit position that is set in any lane and walks only that span. The operation time therefore depends on the weight data as well as on the precision. Weights that are all zero after masking finish at once.

The control side is a plain request/acknowledge pair. The caller raises `start` for one cycle with the operands. The block accepts it only while `busy` is low, so `busy` is the back-pressure signal: a `start` seen while `busy` is high is dropped, not queued. Completion is a one-cycle `done` pulse. `result` holds its value until the next completion.

Top module: `vpm_mac_top`

## Requirements
- R1: With precision 16, `result` equals the exact two's-complement sum act0*wgt0 + act1*wgt1 + act2*wgt2. Lane k occupies bits [16k+15:16k] of `act` and `wgt`, and `result` is 34-bit signed.
- R2: With precision p, each weight magnitude |wgt_k| is first ANDed with a mask that keeps only bit positions 16-p to 15. The result is then the sum over k of sign(wgt_k)*act_k*masked|wgt_k|. A `prec` value of 0 acts as 1, and a value above 16 acts as 16.
- R3: Let lo and hi be the lowest and highest set bit of the OR of the masked magnitudes, and let N = hi-lo+1. Then `busy` is high for exactly N cycles, starting the cycle after the accepted start. `done` is high in the cycle after the last busy cycle, N+1 cycles after the start cycle.
- R4: When every masked magnitude is zero, `result` becomes 0 and `done` is high in the cycle right after the start cycle, and `busy` never rises.
- R5: A `start` seen while `busy` is high is ignored. It does not change the running result and does not begin a second operation.
- R6: `done` is a single-cycle pulse and is never high together with `busy`. `result` changes only in a cycle where `done` is high.
- R7: After reset, `busy`, `done` and `result` are all zero.
- R8: Negative weights, including -32768, and negative activations, including -32768, give correctly signed products. The magnitude of -32768 is bit 15 alone.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request an operation; accepted only while busy is low |
| act | input | 48 | Three signed activations, lane k at [16k+15:16k] |
| wgt | input | 48 | Three signed weights, lane k at [16k+15:16k] |
| prec | input | 5 | Precision in bits, 1 to 16 (0 acts as 1, above 16 acts as 16) |
| busy | output | 1 | High while the serial walk runs |
| done | output | 1 | One-cycle completion pulse |
| result | output | 34 | Signed sum of products, held between completions |

## Verification
The bench targets three classes of corner case.

The first is the sign extremes: -32768 weights and -32768 activations. A design that negates the activation into only 16 bits, or takes a 15-bit magnitude, gets the sign or the size of the 2^30 products wrong.

The second is the span and timing cases: a single set bit, a span from bit 0 to bit 15, and weights that the precision mask turns to zero. A design that miscounts the skipped low positions shifts every partial sum by the wrong amount. A design that mishandles the empty span hangs or takes one cycle too many.

The third is precision truncation and clamping, together with a start raised mid-operation. A wrong mask shows up as a wrong sum. A design that accepts a start while busy corrupts the running result or starts a second operation that was never accepted.

// File: rtl/vpm_pkg.sv
package vpm_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } vpm_state_e;
endpackage

// File: rtl/vpm_sign_fold.sv
// Moves each weight's sign onto its activation; emits unsigned magnitudes.
module vpm_sign_fold #(
  parameter int LANES = 3,
  parameter int AW    = 16,
  parameter int WW    = 16,
  localparam int SAW  = AW + 1
) (
  input  logic [LANES*AW-1:0]  act,
  input  logic [LANES*WW-1:0]  wgt,
  output logic [LANES*SAW-1:0] sact,
  output logic [LANES*WW-1:0]  mag
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic              neg;
    logic signed [AW:0] ax;
    logic [WW-1:0]     wv;
    assign neg = wgt[k*WW + WW - 1];
    assign wv  = wgt[k*WW +: WW];
    assign ax  = {act[k*AW + AW - 1], act[k*AW +: AW]};
    assign mag[k*WW +: WW]    = neg ? (~wv + 1'b1) : wv;
    assign sact[k*SAW +: SAW] = neg ? -ax : ax;
  end
endmodule

// File: rtl/vpm_span_detect.sv
// Applies the precision mask and finds the lowest/highest live bit position.
module vpm_span_detect #(
  parameter int LANES = 3,
  parameter int WW    = 16,
  parameter int PW    = 5,
  localparam int IW   = $clog2(WW)
) (
  input  logic [LANES*WW-1:0] mag,
  input  logic [PW-1:0]       prec,
  output logic [LANES*WW-1:0] mmag,
  output logic                any_set,
  output logic [IW-1:0]       lo,
  output logic [IW-1:0]       hi
);
  int            keep;
  logic [WW-1:0] orv;

  always_comb begin
    keep = int'(prec);
    if (keep < 1)  keep = 1;
    if (keep > WW) keep = WW;
    orv = '0;
    for (int k = 0; k < LANES; k++) begin
      for (int b = 0; b < WW; b++) begin
        mmag[k*WW + b] = (b >= WW - keep) ? mag[k*WW + b] : 1'b0;
        orv[b] = orv[b] | mmag[k*WW + b];
      end
    end
    any_set = |orv;
    lo = '0;
    for (int b = WW - 1; b >= 0; b--) begin
      if (orv[b]) lo = IW'(b);
    end
    hi = '0;
    for (int b = 0; b < WW; b++) begin
      if (orv[b]) hi = IW'(b);
    end
  end
endmodule

// File: rtl/vpm_serial_core.sv
// Walks the live bit span, one position per clock, accumulating shifted partial sums.
module vpm_serial_core
  import vpm_pkg::*;
#(
  parameter int LANES = 3,
  parameter int AW    = 16,
  parameter int WW    = 16,
  parameter int ACCW  = 34,
  localparam int SAW  = AW + 1,
  localparam int IW   = $clog2(WW)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  logic [LANES*SAW-1:0]   sact,
  input  logic [LANES*WW-1:0]    mmag,
  input  logic                   any_set,
  input  logic [IW-1:0]          lo,
  input  logic [IW-1:0]          hi,
  output logic                   busy,
  output logic                   done,
  output logic signed [ACCW-1:0] result
);
  vpm_state_e             state;
  logic [WW-1:0]          sh [LANES];
  logic signed [SAW-1:0]  sa [LANES];
  logic [IW-1:0]          pos;
  logic [IW-1:0]          remain;
  logic signed [ACCW-1:0] acc;
  logic signed [ACCW-1:0] psum;
  logic signed [ACCW-1:0] term;

  assign busy = (state == ST_RUN);

  always_comb begin
    psum = '0;
    for (int k = 0; k < LANES; k++) begin
      if (sh[k][0]) psum = psum + ACCW'(sa[k]);
    end
    term = psum <<< pos;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      done   <= 1'b0;
      result <= '0;
      acc    <= '0;
      pos    <= '0;
      remain <= '0;
      for (int k = 0; k < LANES; k++) begin
        sh[k] <= '0;
        sa[k] <= '0;
      end
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (load) begin
            if (!any_set) begin
              result <= '0;
              done   <= 1'b1;
            end else begin
              for (int k = 0; k < LANES; k++) begin
                sh[k] <= mmag[k*WW +: WW] >> lo;
                sa[k] <= sact[k*SAW +: SAW];
              end
              pos    <= lo;
              remain <= hi - lo;
              acc    <= '0;
              state  <= ST_RUN;
            end
          end
        end
        ST_RUN: begin
          for (int k = 0; k < LANES; k++) sh[k] <= sh[k] >> 1;
          acc    <= acc + term;
          pos    <= pos + 1'b1;
          remain <= remain - 1'b1;
          if (remain == '0) begin
            result <= acc + term;
            done   <= 1'b1;
            state  <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vpm_mac_top.sv
module vpm_mac_top #(
  parameter int LANES = 3,
  parameter int AW    = 16,
  parameter int WW    = 16,
  parameter int PW    = 5,
  parameter int ACCW  = 34
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [LANES*AW-1:0]    act,
  input  logic [LANES*WW-1:0]    wgt,
  input  logic [PW-1:0]          prec,
  output logic                   busy,
  output logic                   done,
  output logic signed [ACCW-1:0] result
);
  localparam int SAW = AW + 1;
  localparam int IW  = $clog2(WW);

  logic [LANES*SAW-1:0] sact;
  logic [LANES*WW-1:0]  mag;
  logic [LANES*WW-1:0]  mmag;
  logic                 any_set;
  logic [IW-1:0]        lo;
  logic [IW-1:0]        hi;
  logic                 load;

  assign load = start & ~busy;

  vpm_sign_fold #(.LANES(LANES), .AW(AW), .WW(WW)) u_fold (
    .act(act), .wgt(wgt), .sact(sact), .mag(mag)
  );

  vpm_span_detect #(.LANES(LANES), .WW(WW), .PW(PW)) u_span (
    .mag(mag), .prec(prec), .mmag(mmag), .any_set(any_set), .lo(lo), .hi(hi)
  );

  vpm_serial_core #(.LANES(LANES), .AW(AW), .WW(WW), .ACCW(ACCW)) u_core (
    .clk(clk), .rst_n(rst_n), .load(load), .sact(sact), .mmag(mmag),
    .any_set(any_set), .lo(lo), .hi(hi),
    .busy(busy), .done(done), .result(result)
  );
endmodule

// File: rtl/vpm_mac_chk.sv
module vpm_mac_chk #(
  parameter int LANES = 3,
  parameter int WW    = 16,
  parameter int ACCW  = 34,
  localparam int RW   = $clog2(WW) + 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   start,
  input logic [LANES*WW-1:0]    wgt,
  input logic                   busy,
  input logic                   done,
  input logic signed [ACCW-1:0] result
);
  logic [RW-1:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_len <= '0;
    else if (busy) run_len <= run_len + 1'b1;
    else           run_len <= '0;
  end

  p_busy_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run_len < RW'(WW)));

  p_busy_from_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  p_zero_weights_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && (wgt == '0)) |=> (done && !busy && (result == '0)));

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_not_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_result_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));
endmodule

bind vpm_mac_top vpm_mac_chk #(.LANES(LANES), .WW(WW), .ACCW(ACCW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .wgt(wgt),
  .busy(busy), .done(done), .result(result)
);

// File: tb/sim_vpm_mac_top.sv
`timescale 1ns/1ps
module sim_vpm_mac_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [47:0] act = '0;
  logic [47:0] wgt = '0;
  logic [4:0]  prec = 5'd16;
  logic        busy;
  logic        done;
  logic signed [33:0] result;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  vpm_mac_top u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .act(act), .wgt(wgt),
    .prec(prec), .busy(busy), .done(done), .result(result)
  );

  task automatic chk(input bit ok, input string req, input longint actv, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, actv, expv);
    end
  endtask

  // Reference: expected sum and expected number of busy cycles.
  task automatic model(input logic signed [15:0] a[3], input logic signed [15:0] w[3],
                       input int p, output longint sum, output int n);
    int pe, keepmask, orv, lo, hi;
    pe = (p < 1) ? 1 : ((p > 16) ? 16 : p);
    keepmask = 16'hFFFF & ~((1 << (16 - pe)) - 1);
    sum = 0; orv = 0;
    for (int k = 0; k < 3; k++) begin
      int m;
      longint sa;
      m  = (w[k] < 0) ? -int'(w[k]) : int'(w[k]);
      m  = m & keepmask;
      sa = (w[k] < 0) ? -longint'(a[k]) : longint'(a[k]);
      sum += sa * longint'(m);
      orv |= m;
    end
    if (orv == 0) n = 0;
    else begin
      lo = -1; hi = 0;
      for (int b = 0; b < 16; b++) if ((orv >> b) & 1) begin
        if (lo < 0) lo = b;
        hi = b;
      end
      n = hi - lo + 1;
    end
  endtask

  task automatic run_op(input logic signed [15:0] a0, a1, a2, w0, w1, w2,
                        input int p, input string req);
    logic signed [15:0] a[3];
    logic signed [15:0] w[3];
    longint exp_sum;
    int n, k, nb;
    a = '{a0, a1, a2};
    w = '{w0, w1, w2};
    model(a, w, p, exp_sum, n);
    @(negedge clk);
    start = 1'b1; act = {a2, a1, a0}; wgt = {w2, w1, w0}; prec = 5'(p);
    @(negedge clk);
    start = 1'b0;
    k = 1; nb = 0;
    while (!done && k < 40) begin
      if (busy) nb++;
      @(negedge clk);
      k++;
    end
    chk(result == exp_sum, {req, " result"}, result, exp_sum);
    chk(k == n + 1, "R3 done latency", k, n + 1);
    chk(nb == n, "R3 busy cycles", nb, n);
  endtask

  task automatic t_reset;
    chk(busy == 1'b0, "R7 busy", busy, 0);
    chk(done == 1'b0, "R7 done", done, 0);
    chk(result == '0, "R7 result", result, 0);
  endtask

  task automatic t_basic;
    run_op(16'sd3, 16'sd5, 16'sd7, 16'sd2, 16'sd4, 16'sd1, 16, "R1 small");
    run_op(16'sd1234, -16'sd77, 16'sd9, 16'sd300, 16'sd1000, 16'sd0, 16, "R1 mixed");
  endtask

  task automatic t_signs;
    run_op(-16'sd100, 16'sd200, -16'sd300, -16'sd7, 16'sd12, -16'sd32768, 16, "R8 negatives");
    run_op(-16'sd32768, -16'sd32768, -16'sd32768, -16'sd32768, -16'sd32768, -16'sd32768, 16, "R8 extremes");
    run_op(16'sd32767, -16'sd32768, 16'sd32767, 16'sd32767, 16'sd32767, -16'sd32767, 16, "R1 largest");
  endtask

  task automatic t_span;
    run_op(16'sd5, 16'sd6, 16'sd7, 16'sh4000, 16'sd0, 16'sd0, 16, "R3 single bit");
    run_op(-16'sd11, 16'sd22, 16'sd33, -16'sd32767, 16'sd0, 16'sd1, 16, "R3 full span");
  endtask

  task automatic t_precision;
    run_op(16'sd17, -16'sd23, 16'sd41, 16'sh1234, 16'sh0F0F, -16'sd5, 8, "R2 truncate p8");
    run_op(16'sd17, -16'sd23, 16'sd41, 16'sh1234, 16'sh7F0F, -16'sd500, 1, "R2 p1");
    run_op(16'sd17, -16'sd23, 16'sd41, 16'sh1234, 16'sh7F0F, -16'sd500, 0, "R2 clamp p0");
    run_op(16'sd17, -16'sd23, 16'sd41, 16'sh1234, 16'sh7F0F, -16'sd500, 20, "R2 clamp p20");
  endtask

  task automatic t_zero;
    run_op(16'sd99, 16'sd88, 16'sd77, 16'sd0, 16'sd0, 16'sd0, 16, "R4 zero weights");
    run_op(16'sd99, 16'sd88, 16'sd77, 16'sd3, -16'sd2, 16'sd0, 4, "R4 masked zero");
  endtask

  task automatic t_start_busy;
    longint exp_sum;
    int n, k, extra;
    logic signed [15:0] a[3];
    logic signed [15:0] w[3];
    a = '{16'sd10, 16'sd20, 16'sd30};
    w = '{16'sh4001, 16'sd3, 16'sd0};
    model(a, w, 16, exp_sum, n);
    @(negedge clk);
    start = 1'b1; act = {16'sd30, 16'sd20, 16'sd10}; wgt = {16'sd0, 16'sd3, 16'sh4001}; prec = 5'd16;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    start = 1'b1; act = {3{16'sd1000}}; wgt = {3{-16'sd1}};
    @(negedge clk);
    @(negedge clk);
    start = 1'b0;
    k = 4;
    while (!done && k < 40) begin @(negedge clk); k++; end
    chk(result == exp_sum, "R5 result unaffected", result, exp_sum);
    chk(k == n + 1, "R5 latency unaffected", k, n + 1);
    extra = 0;
    repeat (20) begin
      @(negedge clk);
      if (done || busy) extra++;
    end
    chk(extra == 0, "R5 no second operation", extra, 0);
  endtask

  task automatic t_hold;
    longint held;
    int bad;
    run_op(16'sd7, 16'sd8, 16'sd9, 16'sd6, 16'sd5, 16'sd4, 16, "R1 hold setup");
    held = result;
    bad = 0;
    act = {3{16'sd555}}; wgt = {3{16'sd77}};
    repeat (6) begin
      @(negedge clk);
      if (done) bad++;
      if (result != held) bad++;
    end
    chk(bad == 0, "R6 pulse and hold", bad, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog R3 actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_signs();
    t_span();
    t_precision();
    t_zero();
    t_start_busy();
    t_hold();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule